// File: doc/BRIEF.md
# SIMD Integer Vector Compare Unit

This unit compares two 128-bit vector operands element by element and writes a 128-bit mask. Each element is all ones where the compare holds and all zeros where it does not. It supports elements of 8, 16, 32 or 64 bits, which gives 16, 8, 4 or 2 lanes. Three compare kinds are available at every width: equality, unsigned greater-than and signed greater-than. A record form also produces a 4-bit condition field. That field reports whether every lane matched or whether no lane matched.

The unit decodes a 10-bit extended opcode itself. The 64-bit integer compares share their index values with floating-point compares, and the two are told apart only by the lowest opcode bit. The unit does not carry out floating-point compares. It flags any such encoding, and any other encoding it does not support, as unsupported. Operands, opcode and the record bit are captured on a valid strobe. The results appear together with a valid pulse one clock later.

Top module: `vcmp_unit`

## Requirements
- R1: The opcode is read as bits [9:6] = index, bits [5:1] = group, bit 0 = low bit. An encoding is supported only when the group is 3 and the index is in 0-3 (equal), 8-11 (unsigned greater-than) or 12-15 (signed greater-than). Within each kind, the index bits [1:0] choose byte, half, word or doubleword. The low bit must be 1 for the doubleword indices (3, 11, 15) and 0 for all others. For example, equal-doubleword is 199 and signed-greater-than-doubleword is 967.
- R2: Lane n of width W occupies result bits [n*W +: W]. It is all ones when the compare holds for that lane and all zeros otherwise.
- R3: Equality compares lanes as unsigned values at every width.
- R4: Unsigned greater-than treats each lane as an unsigned integer at every width.
- R5: Signed greater-than takes the top bit of each lane as that lane's own sign bit. No lane's outcome depends on another lane.
- R6: An unsupported encoding leaves the result and the condition field unchanged. This covers low bit 0 with index 3, 7, 11 or 15 (the floating-point encodings), and every other encoding not listed in R1.
- R7: For a supported record-form operation, the condition field is {all lanes true, 0, no lane true, 0}, so bit 3 is the all-lanes flag and bit 1 is the no-lane flag. For a supported non-record operation, the condition field is 0.
- R8: out_valid is high exactly one clock after a cycle with in_valid high, and low otherwise. After reset, result, condition field, out_valid and unsupported are all zero.
- R9: unsupported is high for an unsupported encoding, only in the cycle when out_valid is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Capture strobe for operands and opcode |
| opnd_a | input | 128 | First vector operand |
| opnd_b | input | 128 | Second vector operand |
| xop | input | 10 | Extended opcode (index, group, low bit) |
| rec | input | 1 | Record form: produce the condition field |
| out_valid | output | 1 | Result valid pulse, one clock after in_valid |
| result | output | 128 | Lane mask result |
| cr_field | output | 4 | {all-true, 0, none-true, 0} |
| unsupported | output | 1 | Encoding was not an integer compare |

## Verification
A wrong decode shows up as a wrong mask, or as a wrongly set or cleared unsupported bit, in the cycle after the strobe. Each operation is checked at that point. A result register that is overwritten on an unsupported encoding stays visible until the next supported operation, and the bench checks the held value right after each rejected encoding. A sign or width error confined to one lane, such as a sign taken from a neighbouring lane, shows up as one wrong lane. The bench targets this with boundary values of 0x80..0 against 0x7F..F in every lane.

// File: rtl/vcmp_unit.sv
module vcmp_unit #(
  parameter int VW = 128
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  input  logic [VW-1:0] opnd_a,
  input  logic [VW-1:0] opnd_b,
  input  logic [9:0]    xop,
  input  logic          rec,
  output logic          out_valid,
  output logic [VW-1:0] result,
  output logic [3:0]    cr_field,
  output logic          unsupported
);
  localparam int NWID = 4;
  localparam logic [4:0] GRP = 5'd3;

  logic [3:0] idx;
  logic [1:0] wsel;
  logic       is_dw, legal;

  assign idx   = xop[9:6];
  assign wsel  = idx[1:0];
  assign is_dw = (wsel == 2'd3);
  assign legal = (xop[5:1] == GRP) && (idx[3:2] != 2'b01) && (xop[0] == is_dw);

  logic [VW-1:0] m [NWID];

  for (genvar wi = 0; wi < NWID; wi++) begin : g_w
    localparam int W = 8 << wi;
    localparam int N = VW / W;
    for (genvar ln = 0; ln < N; ln++) begin : g_l
      logic [W-1:0] la, lb;
      logic eq, ugt, sgt, hit;
      assign la  = opnd_a[ln*W +: W];
      assign lb  = opnd_b[ln*W +: W];
      assign eq  = (la == lb);
      assign ugt = (la > lb);
      assign sgt = ($signed(la) > $signed(lb));
      assign hit = !idx[3] ? eq : (idx[2] ? sgt : ugt);
      assign m[wi][ln*W +: W] = {W{hit}};
    end
  end

  logic [VW-1:0] mask;
  logic all_hit, no_hit;
  assign mask    = m[wsel];
  assign all_hit = &mask;
  assign no_hit  = ~|mask;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid   <= 1'b0;
      unsupported <= 1'b0;
      result      <= '0;
      cr_field    <= '0;
    end else begin
      out_valid   <= in_valid;
      unsupported <= in_valid && !legal;
      if (in_valid && legal) begin
        result   <= mask;
        cr_field <= rec ? {all_hit, 1'b0, no_hit, 1'b0} : 4'b0;
      end
    end
  end

  // R8
  valid_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);
  // R8
  valid_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);
  // R9
  unsup_gated_chk: assert property (@(posedge clk) disable iff (!rst_n)
    unsupported |-> out_valid);
  // R6
  unsup_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !legal) |=> ($stable(result) && $stable(cr_field)));
  // R7
  cr_spare_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cr_field[2] == 1'b0) && (cr_field[0] == 1'b0) && !(cr_field[3] && cr_field[1]));
  // R7
  cr_all_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cr_field[3] |-> (&result));
  // R7
  cr_none_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cr_field[1] |-> (result == '0));
endmodule

// File: tb/vcmp_unit_bench.sv
`timescale 1ns/1ps
module vcmp_unit_bench;
  logic clk = 1'b0, rst_n = 1'b0, in_valid = 1'b0, rec = 1'b0;
  logic [127:0] opnd_a = '0, opnd_b = '0;
  logic [9:0] xop = '0;
  logic out_valid, unsupported;
  logic [127:0] result;
  logic [3:0] cr_field;
  int checks = 0, errors = 0;
  logic [127:0] exp_res = '0;
  logic [3:0] exp_cr = '0;

  always #2.5 clk = ~clk;

  vcmp_unit u_vcmp_unit (.clk(clk), .rst_n(rst_n), .in_valid(in_valid),
    .opnd_a(opnd_a), .opnd_b(opnd_b), .xop(xop), .rec(rec),
    .out_valid(out_valid), .result(result), .cr_field(cr_field),
    .unsupported(unsupported));

  function automatic logic [127:0] ref_cmp(logic [127:0] a, logic [127:0] b, logic [3:0] idx);
    int w = 8 << idx[1:0];
    logic [127:0] r = '0;
    for (int n = 0; n < 128 / w; n++) begin
      logic [63:0] la = '0, lb = '0, sb;
      logic hit;
      for (int k = 0; k < w; k++) begin la[k] = a[n*w+k]; lb[k] = b[n*w+k]; end
      sb = 64'd1 << (w - 1);
      if (!idx[3]) hit = (la == lb);
      else if (!idx[2]) hit = (la > lb);
      else hit = ((la ^ sb) > (lb ^ sb));
      for (int k = 0; k < w; k++) r[n*w+k] = hit;
    end
    return r;
  endfunction

  function automatic logic is_legal(logic [9:0] x);
    logic [3:0] i = x[9:6];
    if (x[5:1] != 5'd3) return 1'b0;
    if (i >= 4 && i <= 7) return 1'b0;
    return x[0] == (i[1:0] == 2'd3);
  endfunction

  task automatic chk(string req, logic [127:0] act, logic [127:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic run_op(string req, logic [127:0] a, logic [127:0] b, logic [9:0] x, logic r);
    @(negedge clk);
    opnd_a = a; opnd_b = b; xop = x; rec = r; in_valid = 1'b1;
    if (is_legal(x)) begin
      exp_res = ref_cmp(a, b, x[9:6]);
      exp_cr = r ? {&exp_res, 1'b0, ~|exp_res, 1'b0} : 4'b0;
    end
    @(negedge clk);
    in_valid = 1'b0;
    chk({req, " R8 out_valid"}, {127'b0, out_valid}, 128'd1);
    chk({req, " R9 unsupported"}, {127'b0, unsupported}, {127'b0, !is_legal(x)});
    chk({req, " R2 result"}, result, exp_res);
    chk({req, " R7 cr"}, {124'b0, cr_field}, {124'b0, exp_cr});
    @(negedge clk);
    chk({req, " R8 pulse"}, {127'b0, out_valid}, 128'd0);
  endtask

  function automatic logic [9:0] mk(logic [3:0] i);
    return {i, 5'd3, i[1:0] == 2'd3};
  endfunction

  initial begin
    #(5.0 * 200000);
    errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [3:0] legal_idx [12] = '{0,1,2,3,8,9,10,11,12,13,14,15};
    logic [127:0] hi, lo;
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    chk("R8 reset out_valid", {127'b0, out_valid}, 128'd0);
    chk("R8 reset result", result, 128'd0);
    chk("R8 reset cr", {124'b0, cr_field}, 128'd0);
    rst_n = 1'b1;
    // R1 fixed encodings
    chk("R1 eq dword code", {118'b0, mk(4'd3)}, 128'd199);
    chk("R1 sgt dword code", {118'b0, mk(4'd15)}, 128'd967);
    // R3 all equal, record form
    hi = {4{32'hDEADBEEF}};
    run_op("R3 eqall", hi, hi, mk(4'd3), 1'b1);
    run_op("R3 eqbyte none", hi, ~hi, mk(4'd0), 1'b1);
    // R5 per-lane sign at every width
    for (int i = 12; i < 16; i++) begin
      int w = 8 << (i - 12);
      hi = '0; lo = '0;
      for (int n = 0; n < 128 / w; n++) begin
        hi[n*w + w - 1] = 1'b0; for (int k = 0; k < w - 1; k++) hi[n*w+k] = 1'b1;
        lo[n*w + w - 1] = 1'b1;
      end
      run_op("R5 sgt boundary", hi, lo, mk(4'(i)), 1'b1);
      run_op("R5 sgt boundary rev", lo, hi, mk(4'(i)), 1'b1);
      run_op("R4 ugt boundary", lo, hi, mk(4'(i - 4)), 1'b1);
    end
    // R6 floating-point encodings and stray codes leave state
    for (int i = 3; i < 16; i += 4)
      run_op("R6 fp code", ~hi, hi, {4'(i), 5'd3, 1'b0}, 1'b1);
    run_op("R6 wrong group", hi, hi, {4'd0, 5'd4, 1'b0}, 1'b1);
    run_op("R6 low bit on byte", hi, hi, {4'd0, 5'd3, 1'b1}, 1'b0);
    // random
    for (int t = 0; t < 400; t++) begin
      logic [127:0] a, b;
      logic [9:0] x;
      a = {$urandom, $urandom, $urandom, $urandom};
      b = {$urandom, $urandom, $urandom, $urandom};
      if ($urandom_range(0, 1)) for (int k = 0; k < 16; k++)
        if ($urandom_range(0, 3) != 0) b[k*8 +: 8] = a[k*8 +: 8];
      if ($urandom_range(0, 9) == 0) x = 10'($urandom);
      else x = mk(legal_idx[$urandom_range(0, 11)]);
      run_op("R3 R4 R5 R7 random", a, b, x, 1'($urandom));
    end
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule